// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block is the control state machine of a single DMA channel. It decides when the channel holds an active transfer sequence and when it may issue bus transfers. It also decides what happens when the sequence ends. A sequence starts from a software write of a nonzero transfer count, or from a trigger that another channel sends on completion. A down-counter tracks the transfers still owed. Each completion pulse from the data path lowers it, and the sequence ends when it reaches zero.

Clearing the enable bit does not end a sequence. It freezes the sequence, and setting enable again resumes it. An abort request ends a sequence at once. A bus error also ends it, sets a sticky per-direction error flag and always raises the interrupt. On normal completion the block pulses a chain trigger that carries a target channel index. A target equal to the channel's own index disables chaining. The interrupt can be raised at every completion, or in a quiet mode only when software writes a zero count, which marks the end of a control-block chain.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `busy`, `issue`, `remaining`, `chain_vld`, `chain_idx`, `irq` and all error flags are 0. Enable and quiet mode are off and the chain target field holds 0.
- R2: A `trig_wr` with nonzero `trig_count` while enabled, idle and error-free sets `busy` and loads `remaining` with the count on the next edge. With enable at 0 the trigger is ignored.
- R3: Each `xfer_done` while `issue` is high lowers `remaining` by one. The pulse that brings it to zero clears `busy` on the same edge.
- R4: Clearing enable while busy pauses the sequence. `busy` stays 1, `issue` drops, `xfer_done` is ignored and `remaining` holds. Setting enable again resumes from the held count.
- R5: A trigger while busy is ignored, and `remaining` is unchanged. Every nonzero `trig_wr` stores its count as the reload value. A `chain_in` pulse starts a sequence with that stored value.
- R6: `abort` clears `busy` and `remaining` on the next edge, with no chain pulse and no interrupt.
- R7: On completion, `chain_vld` is high for exactly one cycle with `chain_idx` equal to the chain target field. No pulse is made when the field equals the parameter `CH_IDX`.
- R8: With quiet mode off, completion sets `irq`. `irq` is sticky until `clr_irq` is pulsed.
- R9: With quiet mode on, completion does not set `irq`. A `trig_wr` with count 0 sets `irq` in quiet mode, has no effect with quiet mode off, and never starts a sequence.
- R10: `rd_err` and `wr_err` set separate sticky flags `rd_err_flag` and `wr_err_flag`, each cleared by its own clear pulse. A set in the same cycle wins over a clear. `bus_err_flag` is their OR.
- R11: A bus error clears `busy` and sets `irq` even in quiet mode. While either error flag is set, triggers are ignored.
- R12: `issue` is high exactly when `busy` is 1, enable is 1 and no error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write enable and quiet-mode bits |
| ctl_en | input | 1 | Enable value to write |
| ctl_quiet | input | 1 | Quiet interrupt mode value to write |
| link_wr | input | 1 | Write the chain target field |
| link_sel | input | CH_W | Chain target channel index to write |
| trig_wr | input | 1 | Trigger register write |
| trig_count | input | CNT_W | Transfer count; 0 is a null trigger |
| chain_in | input | 1 | Trigger arriving from another channel |
| abort | input | 1 | End the current sequence early |
| xfer_done | input | 1 | One transfer completed |
| rd_err | input | 1 | Read bus error pulse |
| wr_err | input | 1 | Write bus error pulse |
| clr_irq | input | 1 | Write-1 clear of the interrupt flag |
| clr_rd_err | input | 1 | Write-1 clear of the read error flag |
| clr_wr_err | input | 1 | Write-1 clear of the write error flag |
| busy | output | 1 | Sequence in progress (also while paused) |
| issue | output | 1 | Channel may issue transfers |
| remaining | output | CNT_W | Transfers left in the sequence |
| chain_vld | output | 1 | One-cycle chain trigger pulse |
| chain_idx | output | CH_W | Channel index the chain trigger targets |
| irq | output | 1 | Sticky interrupt flag |
| rd_err_flag | output | 1 | Sticky read error flag |
| wr_err_flag | output | 1 | Sticky write error flag |
| bus_err_flag | output | 1 | OR of the two error flags |

## Verification
The bench builds the block with four channels, its own index set to 2 and a 4-bit count. Because the own index is not 0, the reset value of the chain field produces a real chain pulse toward channel 0. Setting the field to 2 then shows that chaining is suppressed, and setting it to 3 shows an ordinary target. The narrow count keeps every sequence short, so pause and resume, abort mid-sequence and a trigger during busy can each be walked through transfer by transfer.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  // bit positions inside the sticky flag vector
  localparam int FLG_IRQ = 0;
  localparam int FLG_RD  = 1;
  localparam int FLG_WR  = 2;
  localparam int FLG_N   = 3;

  typedef logic [FLG_N-1:0] flag_vec_t;

  function automatic flag_vec_t pack_flags(input logic irq, input logic rd, input logic wr);
    flag_vec_t v;
    v[FLG_IRQ] = irq;
    v[FLG_RD]  = rd;
    v[FLG_WR]  = wr;
    return v;
  endfunction
endpackage

// File: rtl/dma_seq_cfg.sv
module dma_seq_cfg #(
  parameter int CH_W  = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  logic             ctl_quiet,
  input  logic             link_wr,
  input  logic [CH_W-1:0]  link_sel,
  input  logic             trig_wr,
  input  logic [CNT_W-1:0] trig_count,
  output logic             en_q,
  output logic             quiet_q,
  output logic [CH_W-1:0]  link_q,
  output logic [CNT_W-1:0] reload_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      quiet_q  <= 1'b0;
      link_q   <= '0;
      reload_q <= '0;
    end else begin
      if (ctl_wr) begin
        en_q    <= ctl_en;
        quiet_q <= ctl_quiet;
      end
      if (link_wr) link_q <= link_sel;
      if (trig_wr && (trig_count != '0)) reload_q <= trig_count;
    end
  end
endmodule

// File: rtl/dma_seq_cnt.sv
module dma_seq_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt_q <= '0;
    else if (load)    cnt_q <= load_val;
    else if (dec)     cnt_q <= cnt_q - ONE;
  end

  assign last = (cnt_q == ONE);
endmodule

// File: rtl/dma_seq_flags.sv
module dma_seq_flags
  import dma_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_vec_t set_v,
  input  flag_vec_t clr_v,
  output flag_vec_t q
);
  for (genvar i = 0; i < FLG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           q[i] <= 1'b0;
      else if (set_v[i]) q[i] <= 1'b1;
      else if (clr_v[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_IDX = 0,
  parameter int CNT_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  logic             ctl_quiet,
  input  logic             link_wr,
  input  logic [CH_W-1:0]  link_sel,
  input  logic             trig_wr,
  input  logic [CNT_W-1:0] trig_count,
  input  logic             chain_in,
  input  logic             abort,
  input  logic             xfer_done,
  input  logic             rd_err,
  input  logic             wr_err,
  input  logic             clr_irq,
  input  logic             clr_rd_err,
  input  logic             clr_wr_err,
  output logic             busy,
  output logic             issue,
  output logic [CNT_W-1:0] remaining,
  output logic             chain_vld,
  output logic [CH_W-1:0]  chain_idx,
  output logic             irq,
  output logic             rd_err_flag,
  output logic             wr_err_flag,
  output logic             bus_err_flag
);
  localparam logic [CH_W-1:0] SELF = CH_W'(CH_IDX);

  logic             en_q, quiet_q;
  logic [CH_W-1:0]  link_q;
  logic [CNT_W-1:0] reload_q;
  logic             busy_q;
  logic             cnt_last;
  logic             err_any;
  flag_vec_t        flg_q, flg_set, flg_clr;

  dma_seq_cfg #(.CH_W(CH_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst),
    .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_quiet(ctl_quiet),
    .link_wr(link_wr), .link_sel(link_sel),
    .trig_wr(trig_wr), .trig_count(trig_count),
    .en_q(en_q), .quiet_q(quiet_q), .link_q(link_q), .reload_q(reload_q)
  );

  // start request decode
  logic             sw_start, null_trig, err_now;
  logic [CNT_W-1:0] load_val;
  logic             start_ok, step, finish;

  assign sw_start  = trig_wr && (trig_count != '0);
  assign null_trig = trig_wr && (trig_count == '0);
  assign load_val  = sw_start ? trig_count : reload_q;
  assign err_now   = rd_err || wr_err;
  assign err_any   = flg_q[FLG_RD] || flg_q[FLG_WR];

  assign start_ok = (sw_start || chain_in) && (load_val != '0)
                    && en_q && !busy_q && !err_any && !abort && !err_now;
  assign step     = busy_q && en_q && !err_any && xfer_done && !abort && !err_now;
  assign finish   = step && cnt_last;

  dma_seq_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .clr(abort), .load(start_ok), .load_val(load_val), .dec(step),
    .cnt_q(remaining), .last(cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst)                  busy_q <= 1'b0;
    else if (abort || err_now) busy_q <= 1'b0;
    else if (finish)          busy_q <= 1'b0;
    else if (start_ok)        busy_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_vld <= 1'b0;
      chain_idx <= '0;
    end else begin
      chain_vld <= finish && (link_q != SELF);
      if (finish) chain_idx <= link_q;
    end
  end

  assign flg_set = pack_flags(err_now || (finish && !quiet_q) || (null_trig && quiet_q),
                              rd_err, wr_err);
  assign flg_clr = pack_flags(clr_irq, clr_rd_err, clr_wr_err);

  dma_seq_flags u_flags (
    .clk(clk), .rst(rst), .set_v(flg_set), .clr_v(flg_clr), .q(flg_q)
  );

  assign busy         = busy_q;
  assign issue        = busy_q && en_q && !err_any;
  assign irq          = flg_q[FLG_IRQ];
  assign rd_err_flag  = flg_q[FLG_RD];
  assign wr_err_flag  = flg_q[FLG_WR];
  assign bus_err_flag = err_any;
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int CH_W   = 4,
  parameter int CNT_W  = 16,
  parameter int CH_IDX = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             en_q,
  input logic             trig_wr,
  input logic             chain_in,
  input logic             abort,
  input logic             xfer_done,
  input logic             rd_err,
  input logic             wr_err,
  input logic             clr_rd_err,
  input logic             busy,
  input logic [CNT_W-1:0] remaining,
  input logic             chain_vld,
  input logic [CH_W-1:0]  chain_idx,
  input logic             irq,
  input logic             rd_err_flag
);
  // R3: busy only falls because of a transfer, abort or error
  p_busy_fall_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(xfer_done || abort || rd_err || wr_err));

  // R4: a paused sequence keeps busy and its count
  p_pause_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !en_q && !abort && !rd_err && !wr_err) |=> (busy && $stable(remaining)));

  // R5: while busy, triggers do not touch the count
  p_busy_trig_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && (trig_wr || chain_in) && !xfer_done && !abort) |=> $stable(remaining));

  // R6: abort ends the sequence without a chain pulse
  p_abort_clears_r6: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!busy && remaining == '0 && !chain_vld));

  // R7: chain pulse never targets the own channel and comes after busy
  p_no_self_chain_r7: assert property (@(posedge clk) disable iff (rst)
    chain_vld |-> (chain_idx != CH_W'(CH_IDX) && !busy && $past(busy)));

  // R7: pulse lasts one cycle
  p_chain_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    chain_vld |=> !chain_vld);

  // R10: read error flag is sticky without a clear
  p_rd_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_err_flag && !clr_rd_err) |=> rd_err_flag);

  // R11: an error halts the channel and raises the interrupt
  p_err_halts_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_err || wr_err) |=> (!busy && irq));
endmodule

bind dma_chan_seq dma_seq_chk #(.CH_W(CH_W), .CNT_W(CNT_W), .CH_IDX(CH_IDX)) u_seq_chk (
  .clk(clk), .rst(rst), .en_q(en_q), .trig_wr(trig_wr), .chain_in(chain_in),
  .abort(abort), .xfer_done(xfer_done), .rd_err(rd_err), .wr_err(wr_err),
  .clr_rd_err(clr_rd_err), .busy(busy), .remaining(remaining),
  .chain_vld(chain_vld), .chain_idx(chain_idx), .irq(irq), .rd_err_flag(rd_err_flag)
);

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;
  localparam int NUM_CH = 4;
  localparam int CH_IDX = 2;
  localparam int CNT_W  = 4;
  localparam int CH_W   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 0, ctl_en = 0, ctl_quiet = 0, link_wr = 0;
  logic [CH_W-1:0]  link_sel = '0;
  logic trig_wr = 0;
  logic [CNT_W-1:0] trig_count = '0;
  logic chain_in = 0, abort = 0, xfer_done = 0, rd_err = 0, wr_err = 0;
  logic clr_irq = 0, clr_rd_err = 0, clr_wr_err = 0;
  logic busy, issue, chain_vld, irq, rd_err_flag, wr_err_flag, bus_err_flag;
  logic [CNT_W-1:0] remaining;
  logic [CH_W-1:0]  chain_idx;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  dma_chan_seq #(.NUM_CH(NUM_CH), .CH_IDX(CH_IDX), .CNT_W(CNT_W)) i_dma_chan_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_quiet(ctl_quiet),
    .link_wr(link_wr), .link_sel(link_sel), .trig_wr(trig_wr), .trig_count(trig_count),
    .chain_in(chain_in), .abort(abort), .xfer_done(xfer_done), .rd_err(rd_err),
    .wr_err(wr_err), .clr_irq(clr_irq), .clr_rd_err(clr_rd_err), .clr_wr_err(clr_wr_err),
    .busy(busy), .issue(issue), .remaining(remaining), .chain_vld(chain_vld),
    .chain_idx(chain_idx), .irq(irq), .rd_err_flag(rd_err_flag),
    .wr_err_flag(wr_err_flag), .bus_err_flag(bus_err_flag)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic e, input logic q);
    ctl_wr = 1; ctl_en = e; ctl_quiet = q; tick(); ctl_wr = 0;
  endtask
  task automatic set_link(input int t);
    link_wr = 1; link_sel = CH_W'(t); tick(); link_wr = 0;
  endtask
  task automatic trig(input int c);
    trig_wr = 1; trig_count = CNT_W'(c); tick(); trig_wr = 0;
  endtask
  task automatic xfer();
    xfer_done = 1; tick(); xfer_done = 0;
  endtask
  task automatic do_abort();
    abort = 1; tick(); abort = 0;
  endtask
  task automatic clear_irq();
    clr_irq = 1; tick(); clr_irq = 0;
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 issue", int'(issue), 0);
    chk("R1 remaining", int'(remaining), 0);
    chk("R1 chain_vld", int'(chain_vld), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 err", int'(bus_err_flag), 0);
  endtask

  task automatic t_disabled();
    trig(5);
    chk("R2 disabled trigger busy", int'(busy), 0);
    chk("R2 disabled trigger remaining", int'(remaining), 0);
  endtask

  task automatic t_basic();
    set_ctl(1, 0);
    trig(3);
    chk("R2 busy", int'(busy), 1);
    chk("R2 remaining", int'(remaining), 3);
    chk("R12 issue", int'(issue), 1);
    xfer();
    chk("R3 rem2", int'(remaining), 2);
    xfer();
    chk("R3 rem1", int'(remaining), 1);
    chk("R3 busy mid", int'(busy), 1);
    xfer();
    chk("R3 busy end", int'(busy), 0);
    chk("R3 rem end", int'(remaining), 0);
    chk("R7 chain_vld", int'(chain_vld), 1);
    chk("R1 default chain target", int'(chain_idx), 0);
    chk("R8 irq", int'(irq), 1);
    tick();
    chk("R7 one cycle", int'(chain_vld), 0);
    chk("R8 sticky", int'(irq), 1);
    clear_irq();
    chk("R8 cleared", int'(irq), 0);
  endtask

  task automatic t_pause();
    trig(4);
    xfer();
    chk("R4 rem before", int'(remaining), 3);
    set_ctl(0, 0);
    chk("R4 busy paused", int'(busy), 1);
    chk("R12 issue paused", int'(issue), 0);
    xfer();
    xfer();
    chk("R4 rem held", int'(remaining), 3);
    chk("R4 still busy", int'(busy), 1);
    set_ctl(1, 0);
    chk("R12 issue resumed", int'(issue), 1);
    xfer();
    chk("R4 resume rem", int'(remaining), 2);
    xfer(); xfer();
    chk("R4 done", int'(busy), 0);
    clear_irq();
  endtask

  task automatic t_busy_trig_abort();
    trig(4);
    trig(9);
    chk("R5 rem kept", int'(remaining), 4);
    do_abort();
    chk("R6 busy", int'(busy), 0);
    chk("R6 rem", int'(remaining), 0);
    chk("R6 chain", int'(chain_vld), 0);
    chk("R6 irq", int'(irq), 0);
    chain_in = 1; tick(); chain_in = 0;
    chk("R5 chain start busy", int'(busy), 1);
    chk("R5 chain start reload", int'(remaining), 9);
    do_abort();
  endtask

  task automatic t_links();
    set_link(CH_IDX);
    trig(1);
    xfer();
    chk("R7 self no chain", int'(chain_vld), 0);
    chk("R8 irq self", int'(irq), 1);
    clear_irq();
    set_link(3);
    trig(2);
    xfer(); xfer();
    chk("R7 chain vld 3", int'(chain_vld), 1);
    chk("R7 chain idx 3", int'(chain_idx), 3);
    clear_irq();
  endtask

  task automatic t_quiet();
    set_ctl(1, 1);
    trig(2);
    xfer(); xfer();
    chk("R9 quiet completion busy", int'(busy), 0);
    chk("R9 quiet no irq", int'(irq), 0);
    trig(0);
    chk("R9 null irq", int'(irq), 1);
    chk("R9 null no start", int'(busy), 0);
    clear_irq();
    set_ctl(1, 0);
    trig(0);
    chk("R9 null non-quiet", int'(irq), 0);
    chk("R9 null non-quiet busy", int'(busy), 0);
  endtask

  task automatic t_errors();
    set_ctl(1, 1);
    trig(5);
    rd_err = 1; tick(); rd_err = 0;
    chk("R11 halt", int'(busy), 0);
    chk("R11 irq quiet", int'(irq), 1);
    chk("R10 rd flag", int'(rd_err_flag), 1);
    chk("R10 wr flag", int'(wr_err_flag), 0);
    chk("R10 or", int'(bus_err_flag), 1);
    trig(3);
    chk("R11 trig blocked", int'(busy), 0);
    wr_err = 1; rd_err = 1; clr_rd_err = 1; tick();
    wr_err = 0; rd_err = 0; clr_rd_err = 0;
    chk("R10 set wins", int'(rd_err_flag), 1);
    chk("R10 wr set", int'(wr_err_flag), 1);
    clr_rd_err = 1; tick(); clr_rd_err = 0;
    chk("R10 rd clr", int'(rd_err_flag), 0);
    chk("R10 or wr", int'(bus_err_flag), 1);
    clr_wr_err = 1; tick(); clr_wr_err = 0;
    chk("R10 or clear", int'(bus_err_flag), 0);
    clear_irq();
    chk("R8 irq clr", int'(irq), 0);
    trig(3);
    chk("R11 restart", int'(remaining), 3);
    chk("R12 issue restart", int'(issue), 1);
    do_abort();
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    t_reset();
    t_disabled();
    t_basic();
    t_pause();
    t_busy_trig_abort();
    t_links();
    t_quiet();
    t_errors();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule